// File: doc/BRIEF.md
# Second-Level Cache Fault Address Capture Register

This block records the first asynchronous error reported by a second-level cache. It stores a code for the error's class and physical address bits 42 down to 3, and software reads both back through a small register port. Once an error is recorded the register keeps it, and later reports are ignored. Software releases the register by writing to it. Every write empties the register completely, whatever the write data is.

The error class decides how fine the stored address is. A correctable error on incoming data and an uncorrectable raw error during a fill both store the address of the failing doubleword. An uncorrectable raw error inside the cache array stores the address of the 64-byte line, and the three address bits below the line boundary are forced to zero.

A two-state controller, `ST_EMPTY` and `ST_HELD`, decides when the register loads. There are three transitions:
- **capture**: `ST_EMPTY` to `ST_HELD`, on a report with a non-zero class and no write in the same cycle.
- **release**: `ST_HELD` to `ST_EMPTY`, on any write.
- **hold**: every other case. This includes `ST_EMPTY` when a report and a write arrive together; the write wins.

Top module: `fault_addr_reg`

## Requirements
- R1: After reset the register is empty: `held`=0 and `rd_ack`=0, and a read returns all zeros.
- R2: A report with `err_kind`=1 loads code 0x40 into bits 63:56 and `err_pa` (PA[42:3]) unchanged into bits 42:3.
- R3: A report with `err_kind`=2 loads code 0x80 into bits 63:56 and the doubleword address unchanged into bits 42:3.
- R4: A report with `err_kind`=3 loads code 0xC0 into bits 63:56, with bits 42:6 taken from the address and bits 5:3 forced to zero.
- R5: Bits 55:43 and 2:0 always read as zero.
- R6: While an error is held, further reports change neither the stored value nor `held`.
- R7: A write (`reg_we`=1) with any `reg_wdata` empties the whole register on the next edge.
- R8: If a report and a write occur in the same cycle, the register ends up empty. The report is captured on the following cycle only if it is still present then.
- R9: A report with `err_kind`=0 is ignored.
- R10: `rd_en` in one cycle gives `rd_ack`=1 and `rd_data` in the next cycle. The data is the register value before that edge, so a read in the same cycle as a write returns the old value.
- R11: `held` is 1 exactly when the stored code is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_report | input | 1 | An error report is present this cycle |
| err_kind | input | 2 | Error class: 0 none, 1 correctable incoming, 2 raw fill, 3 raw in-array |
| err_pa | input | 40 | Physical address bits 42:3 of the error |
| reg_we | input | 1 | Register write strobe (clears the register) |
| reg_wdata | input | 64 | Write data, ignored |
| rd_en | input | 1 | Register read request |
| rd_ack | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 64 | Register read value |
| held | output | 1 | An error is recorded |

## Verification
Directed sequences drive each error class with distinctive address patterns: all ones, alternating bits, and low bits set. These show whether the right code is used and whether the low-bit masking applies to the line class only. Back-to-back reports of different classes separate first-error hold from overwrite. Writes with zero and with all-ones data show that the clear does not depend on the data. Same-cycle write and report, and same-cycle read and write, pin down which side wins. A long random mix of all inputs is compared cycle by cycle against a behavioural model to catch ordering mistakes the directed cases miss.

// File: rtl/fault_pkg.sv
package fault_pkg;

    typedef enum logic [1:0] {
        KIND_NONE    = 2'd0,
        KIND_CE_IN   = 2'd1,
        KIND_UE_FILL = 2'd2,
        KIND_UE_LINE = 2'd3
    } err_kind_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } cap_state_e;

    localparam int CODE_W = 8;

    function automatic logic [CODE_W-1:0] kind_code(input err_kind_e k);
        logic [CODE_W-1:0] c;
        case (k)
            KIND_CE_IN:   c = 8'h40;
            KIND_UE_FILL: c = 8'h80;
            KIND_UE_LINE: c = 8'hC0;
            default:      c = 8'h00;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fault_fsm.sv
module fault_fsm
    import fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rep_ok,
    input  logic wr_clr,
    output logic load,
    output logic clear
);

    cap_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (!wr_clr && rep_ok) state_d = ST_HELD;
            ST_HELD:  if (wr_clr)            state_d = ST_EMPTY;
            default:                         state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        load  = 1'b0;
        clear = wr_clr;
        unique case (state_q)
            ST_EMPTY: load = rep_ok && !wr_clr;
            ST_HELD:  load = 1'b0;
            default:  load = 1'b0;
        endcase
    end

endmodule

// File: rtl/fault_capture.sv
module fault_capture
    import fault_pkg::*;
#(
    parameter int PA_W      = 40,
    parameter int LINE_DROP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  err_kind_e         kind,
    input  logic [PA_W-1:0]   pa,
    output logic [CODE_W-1:0] code_q,
    output logic [PA_W-1:0]   pa_q
);

    logic [PA_W-1:0] pa_fmt;

    generate
        if (LINE_DROP > 0) begin : g_mask
            always_comb begin
                pa_fmt = pa;
                if (kind == KIND_UE_LINE) pa_fmt[LINE_DROP-1:0] = '0;
            end
        end else begin : g_nomask
            assign pa_fmt = pa;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            pa_q   <= '0;
        end else if (clear) begin
            code_q <= '0;
            pa_q   <= '0;
        end else if (load) begin
            code_q <= kind_code(kind);
            pa_q   <= pa_fmt;
        end
    end

endmodule

// File: rtl/fault_readport.sv
module fault_readport #(
    parameter int WORD_W   = 64,
    parameter int CODE_W   = 8,
    parameter int CODE_LSB = 56,
    parameter int PA_W     = 40,
    parameter int PA_LSB   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [CODE_W-1:0] code_q,
    input  logic [PA_W-1:0]   pa_q,
    output logic              rd_ack,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] word;

    always_comb begin
        word = '0;
        word[CODE_LSB +: CODE_W] = code_q;
        word[PA_LSB +: PA_W]     = pa_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ack  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_ack <= rd_en;
            if (rd_en) rd_data <= word;
        end
    end

endmodule

// File: rtl/fault_addr_reg.sv
module fault_addr_reg
    import fault_pkg::*;
#(
    parameter int WORD_W   = 64,
    parameter int PA_HI    = 42,
    parameter int PA_LO    = 3,
    parameter int LINE_LSB = 6,
    parameter int CODE_LSB = 56
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    err_report,
    input  logic [1:0]              err_kind,
    input  logic [PA_HI-PA_LO:0]    err_pa,
    input  logic                    reg_we,
    input  logic [WORD_W-1:0]       reg_wdata,
    input  logic                    rd_en,
    output logic                    rd_ack,
    output logic [WORD_W-1:0]       rd_data,
    output logic                    held
);

    localparam int PA_W      = PA_HI - PA_LO + 1;
    localparam int LINE_DROP = LINE_LSB - PA_LO;

    err_kind_e         kind;
    logic              rep_ok;
    logic              load;
    logic              clear;
    logic [CODE_W-1:0] code_q;
    logic [PA_W-1:0]   pa_q;

    assign kind   = err_kind_e'(err_kind);
    assign rep_ok = err_report && (kind != KIND_NONE);

    fault_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .rep_ok (rep_ok),
        .wr_clr (reg_we),
        .load   (load),
        .clear  (clear)
    );

    fault_capture #(
        .PA_W      (PA_W),
        .LINE_DROP (LINE_DROP)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .clear  (clear),
        .kind   (kind),
        .pa     (err_pa),
        .code_q (code_q),
        .pa_q   (pa_q)
    );

    fault_readport #(
        .WORD_W   (WORD_W),
        .CODE_W   (CODE_W),
        .CODE_LSB (CODE_LSB),
        .PA_W     (PA_W),
        .PA_LSB   (PA_LO)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .code_q  (code_q),
        .pa_q    (pa_q),
        .rd_ack  (rd_ack),
        .rd_data (rd_data)
    );

    assign held = (code_q != '0);

endmodule

// File: rtl/fault_addr_chk.sv
module fault_addr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        err_report,
    input logic [1:0]  err_kind,
    input logic        reg_we,
    input logic [63:0] reg_wdata,
    input logic        rd_en,
    input logic        rd_ack,
    input logic [63:0] rd_data,
    input logic        held
);

    // R10
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack == $past(rd_en));

    // R7
    wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_wdata != 64'd0 || reg_wdata == 64'd0)) |=> !held);

    // R6
    first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !reg_we) |=> held);

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && err_report && err_kind != 2'd0 && !reg_we) |=> held);

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && !(err_report && err_kind != 2'd0)) |=> !held);

    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> (rd_data[55:43] == 13'd0 && rd_data[2:0] == 3'd0));

    // R4
    line_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && rd_data[63:56] == 8'hC0) |-> rd_data[5:3] == 3'd0);

endmodule

bind fault_addr_reg fault_addr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_report (err_report),
    .err_kind   (err_kind),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .rd_en      (rd_en),
    .rd_ack     (rd_ack),
    .rd_data    (rd_data),
    .held       (held)
);

// File: tb/sim_fault_addr_reg.sv
module sim_fault_addr_reg;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_report = 1'b0;
    logic [1:0]  err_kind = 2'd0;
    logic [39:0] err_pa = '0;
    logic        reg_we = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic        rd_en = 1'b0;
    logic        rd_ack;
    logic [63:0] rd_data;
    logic        held;

    int vectors = 0;
    int errors  = 0;
    string cur_req = "R1";

    logic [63:0] m_reg;
    logic [63:0] m_rd;
    logic        m_ack;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_addr_reg u0 (
        .clk(clk), .rst_n(rst_n), .err_report(err_report), .err_kind(err_kind),
        .err_pa(err_pa), .reg_we(reg_we), .reg_wdata(reg_wdata), .rd_en(rd_en),
        .rd_ack(rd_ack), .rd_data(rd_data), .held(held)
    );

    function automatic logic [63:0] build(input logic [1:0] k, input logic [39:0] pa);
        logic [63:0] v;
        logic [39:0] a;
        logic [7:0]  c;
        c = (k == 2'd1) ? 8'h40 : (k == 2'd2) ? 8'h80 : 8'hC0;
        a = (k == 2'd3) ? (pa & ~40'h7) : pa;
        v = 64'd0;
        v = v | ({56'd0, c} << 56);
        v = v | ({24'd0, a} << 3);
        return v;
    endfunction

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reg <= 64'd0;
            m_rd  <= 64'd0;
            m_ack <= 1'b0;
        end else begin
            m_ack <= rd_en;
            if (rd_en) m_rd <= m_reg;
            if (reg_we) m_reg <= 64'd0;
            else if (m_reg == 64'd0 && err_report && err_kind != 2'd0)
                m_reg <= build(err_kind, err_pa);
        end
    end

    task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // sample at the falling edge, then compare against the model
    task automatic step();
        @(negedge clk);
        cmp({cur_req, "/R11 held"}, {63'd0, held}, {63'd0, (m_reg != 64'd0)});
        cmp({cur_req, "/R10 ack"}, {63'd0, rd_ack}, {63'd0, m_ack});
        if (m_ack) cmp({cur_req, " rdata"}, rd_data, m_rd);
    endtask

    task automatic idle();
        err_report = 0; err_kind = 0; reg_we = 0; rd_en = 0; reg_wdata = '0;
    endtask

    // read the register and check the word against an expected value
    task automatic read_check(input string req, input logic [63:0] exp);
        idle(); rd_en = 1;
        step();
        rd_en = 0;
        step();
        cmp(req, rd_data, exp);
    endtask

    task automatic report(input logic [1:0] k, input logic [39:0] pa);
        idle(); err_report = 1; err_kind = k; err_pa = pa;
        step();
        idle();
    endtask

    task automatic wipe(input logic [63:0] d);
        idle(); reg_we = 1; reg_wdata = d;
        step();
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        cur_req = "R1";
        cmp("R1 held", {63'd0, held}, 64'd0);
        cmp("R1 ack", {63'd0, rd_ack}, 64'd0);
        read_check("R1 read", 64'd0);

        // R2 correctable incoming
        cur_req = "R2";
        report(2'd1, 40'hFF_FFFF_FFFF);
        read_check("R2", 64'h4000_07FF_FFFF_FFF8);
        wipe(64'd0);

        // R3 raw fill, low bits kept
        cur_req = "R3";
        report(2'd2, 40'hAA_AAAA_AAAF);
        read_check("R3", build(2'd2, 40'hAA_AAAA_AAAF));
        wipe(64'hFFFF_FFFF_FFFF_FFFF);

        // R4 line class, bits 5:3 forced zero; R5 reserved zero
        cur_req = "R4";
        report(2'd3, 40'hFF_FFFF_FFFF);
        read_check("R4", 64'hC000_07FF_FFFF_FFC0);
        cur_req = "R5";
        read_check("R5", 64'hC000_07FF_FFFF_FFC0);

        // R6 later report ignored while held
        cur_req = "R6";
        report(2'd1, 40'h12_3456_789A);
        read_check("R6", 64'hC000_07FF_FFFF_FFC0);

        // R7 write of all ones clears
        cur_req = "R7";
        wipe(64'hFFFF_FFFF_FFFF_FFFF);
        cmp("R7 held", {63'd0, held}, 64'd0);
        read_check("R7", 64'd0);

        // R9 kind 0 ignored
        cur_req = "R9";
        report(2'd0, 40'h55_5555_5555);
        cmp("R9 held", {63'd0, held}, 64'd0);
        read_check("R9", 64'd0);

        // R8 write and report together; held report captured next cycle
        cur_req = "R8";
        idle(); err_report = 1; err_kind = 2'd2; err_pa = 40'h01_0203_0405; reg_we = 1;
        step();
        cmp("R8 clear wins", {63'd0, held}, 64'd0);
        reg_we = 0;
        step();
        cmp("R8 recapture", {63'd0, held}, 64'd1);
        idle();
        read_check("R8", build(2'd2, 40'h01_0203_0405));

        // R10 read alongside a write returns the old value
        cur_req = "R10";
        idle(); rd_en = 1; reg_we = 1;
        step();
        idle();
        cmp("R10 old value", rd_data, build(2'd2, 40'h01_0203_0405));
        cmp("R10 ack", {63'd0, rd_ack}, 64'd1);
        read_check("R10 after", 64'd0);

        // random mix against the model
        cur_req = "rand";
        for (int i = 0; i < 3000; i++) begin
            err_report = ($urandom_range(0, 3) != 0);
            err_kind   = 2'($urandom_range(0, 3));
            err_pa     = {8'($urandom), 32'($urandom)};
            reg_we     = ($urandom_range(0, 9) == 0);
            reg_wdata  = {32'($urandom), 32'($urandom)};
            rd_en      = ($urandom_range(0, 1) == 1);
            step();
        end
        idle();
        step();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule